// File: doc/BRIEF.md
# DVFS Load Tracker and Frequency Request Generator

This block watches how busy a processor core is and turns that into a request to change its operating point. On each slow sampling tick it takes a 6-bit load reading and adds a weight for each side activity input that is active. The sum saturates at the load maximum. A source select decides whether the averaging stage sees this new sample or the one from the tick before. The chosen sample feeds an exponential moving average whose time constant is a programmable shift.

Every updated average is compared with three thresholds. The block raises an increase or decrease request only when the average has stayed past the up or down threshold for a programmed number of consecutive samples. It raises an emergency request as soon as the average reaches the panic threshold. No request is raised that would move past the lowest or highest operating level. A raised request holds its code and its interrupt until software acknowledges it with a one-cycle pulse. Typical programming is an up threshold of 30 held for 0x33 samples, a down threshold of 18 held for 0x33 samples, a panic threshold of 63, a divider of 3, an average of about 32 samples (shift 5), and weight 7 on side inputs 12 to 15.

Top module: `dvfs_load_tracker`

## Requirements
- R1: After reset `req_code` is 0 and `irq` is 0.
- R2: While `en` is high, a load sample is taken once every `tick_div`+1 clock cycles, counting from the rising edge of `en`. The updated average is judged on the following cycle. While `en` is low, no sampling or judgement happens.
- R3: The sample is `load_in` plus `gp_wgt[3*i+2:3*i]` for every `gp_act[i]` that is high, saturated at 63. A weight of 0 adds nothing.
- R4: With `src_cur`=1 the average takes the sample of the current tick. With `src_cur`=0 it takes the sample captured on the previous tick, which is 0 on the first tick after reset.
- R5: The average is kept with 8 fraction bits and updated as avg += (sample - avg) >>> `ema_shift`, where the shift is arithmetic. The integer part is the value compared. A shift of 0 makes the average equal the sample.
- R6: Code 1 (increase) is raised at the judgement where the average has been strictly above `up_thr` for `up_need` consecutive judgements, counting this one. An `up_need` of 0 acts as 1.
- R7: Code 2 (decrease) is raised likewise when the average has been strictly below `dn_thr` for `dn_need` consecutive judgements.
- R8: Code 3 (emergency) is raised at the first judgement where the average is at or above `pnc_thr`, with no persistence. It takes priority over increase, and increase takes priority over decrease.
- R9: At `level`=0 no decrease is raised. At `level`=3 neither increase nor emergency is raised.
- R10: A request is raised only while `en`=1, `irq_mask`=0 and `upd_ok`=1. A request that was held back is raised at the first judgement where all three hold.
- R11: A persistence count restarts from zero at any judgement where its condition fails. Both counts restart after any request is raised.
- R12: Once raised, `req_code` and `irq` hold until `ack` is high on a clock edge. That edge clears both to 0. No new request is raised while `irq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Tracking enable |
| irq_mask | input | 1 | Blocks new requests when high |
| upd_ok | input | 1 | High when the previous operating-point change has completed |
| level | input | 2 | Current operating level, 0 lowest, 3 highest |
| ack | input | 1 | Write-one-to-clear pulse for the pending request |
| tick_div | input | 4 | Sampling divider, period is value+1 cycles |
| load_in | input | 6 | Raw core load reading |
| gp_act | input | 16 | Side activity inputs |
| gp_wgt | input | 48 | Packed 3-bit weights, input i at bits 3i+2:3i |
| src_cur | input | 1 | 1 selects the current sample, 0 the previous sample |
| ema_shift | input | 3 | Averaging shift |
| up_thr | input | 6 | Increase threshold |
| dn_thr | input | 6 | Decrease threshold |
| pnc_thr | input | 6 | Emergency threshold |
| up_need | input | 8 | Samples required above `up_thr` |
| dn_need | input | 8 | Samples required below `dn_thr` |
| req_code | output | 2 | 0 none, 1 increase, 2 decrease, 3 emergency |
| irq | output | 1 | Request pending |

## Verification
The bench times each request to the exact judgement cycle. A persistence count that is off by one, or that does not restart after a failed sample or after a raised request, makes the request appear one or more sample periods early or late. Saturation of the weighted sum is tested by driving a sum that would wrap to a small value without it. An unsaturated adder then misses the emergency. The previous-sample mode and a shift of 1 each delay the request by a known number of samples, so a wrong source select or an average that rounds differently moves the request. Requests that should be held back at the level limits, while masked or while `upd_ok` is low, or while an earlier request waits for its acknowledge, are checked for staying absent. The held-back cases are also checked for appearing on the first allowed judgement.

// File: rtl/dvfs_lt_pkg.sv
package dvfs_lt_pkg;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_UP    = 2'd1,
    REQ_DOWN  = 2'd2,
    REQ_EMERG = 2'd3
  } req_e;

  // clamp a non-negative sum to a ceiling
  function automatic int sat_to(int v, int ceil_v);
    return (v > ceil_v) ? ceil_v : v;
  endfunction

  // one step of the shift-based exponential average
  function automatic int ema_step(int acc, int target, int shift);
    int delta;
    delta = target - acc;
    return acc + (delta >>> shift);
  endfunction

  // persistence reached once count+1 meets the need (need 0 acts as 1)
  function automatic logic need_met(int cnt, int need);
    return (cnt + 1) >= need;
  endfunction

endpackage

// File: rtl/dvfs_lt_tick.sv
module dvfs_lt_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = en && (cnt_q >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!en)      cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // R2: ticks are separated by at least one idle cycle unless the divider is 0
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div != '0) |=> !tick || (div == '0));

endmodule

// File: rtl/dvfs_lt_avg.sv
module dvfs_lt_avg
  import dvfs_lt_pkg::*;
#(
  parameter int LOAD_W = 6,
  parameter int NUM_GP = 16,
  parameter int WGT_W  = 3,
  parameter int FRAC_W = 8,
  parameter int K_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [LOAD_W-1:0]       load_in,
  input  logic [NUM_GP-1:0]       gp_act,
  input  logic [NUM_GP*WGT_W-1:0] gp_wgt,
  input  logic                    src_cur,
  input  logic [K_W-1:0]          ema_shift,
  output logic [LOAD_W-1:0]       avg,
  output logic                    avg_vld
);
  localparam int ACC_W    = LOAD_W + FRAC_W;
  localparam int LOAD_MAX = (1 << LOAD_W) - 1;

  logic [WGT_W-1:0]  term [NUM_GP];
  logic [LOAD_W-1:0] sample_now;
  logic [LOAD_W-1:0] last_q;
  logic [LOAD_W-1:0] pick;
  logic [ACC_W-1:0]  acc_q;
  logic              vld_q;

  for (genvar g = 0; g < NUM_GP; g++) begin : g_term
    assign term[g] = gp_act[g] ? gp_wgt[g*WGT_W +: WGT_W] : '0;
  end

  always_comb begin
    int tot;
    tot = int'(load_in);
    for (int i = 0; i < NUM_GP; i++) tot += int'(term[i]);
    sample_now = LOAD_W'(sat_to(tot, LOAD_MAX));
  end

  assign pick = src_cur ? sample_now : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      acc_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= tick;
      if (tick) begin
        last_q <= sample_now;
        acc_q  <= ACC_W'(ema_step(int'(acc_q), int'({pick, {FRAC_W{1'b0}}}),
                                  int'(ema_shift)));
      end
    end
  end

  assign avg     = acc_q[ACC_W-1 -: LOAD_W];
  assign avg_vld = vld_q;

  // R5: with no shift the judged average is the sample picked on the tick
  p_avg_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (ema_shift == '0) |=> avg == $past(pick));

  // R2: a judgement follows each tick
  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> avg_vld);

endmodule

// File: rtl/dvfs_lt_decide.sv
module dvfs_lt_decide
  import dvfs_lt_pkg::*;
#(
  parameter int LOAD_W = 6,
  parameter int CNT_W  = 8,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [LOAD_W-1:0] avg,
  input  logic [LOAD_W-1:0] up_thr,
  input  logic [LOAD_W-1:0] dn_thr,
  input  logic [LOAD_W-1:0] pnc_thr,
  input  logic [CNT_W-1:0]  up_need,
  input  logic [CNT_W-1:0]  dn_need,
  input  logic              en,
  input  logic              irq_mask,
  input  logic              upd_ok,
  input  logic [LVL_W-1:0]  level,
  input  logic              ack,
  output logic [1:0]        req_code,
  output logic              irq
);
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  logic [CNT_W-1:0] up_cnt, dn_cnt;
  logic             up_cond, dn_cond, pnc_cond, up_full, dn_full;
  logic             at_top, at_bottom, gate_ok, issue;
  req_e             cand, req_q;
  logic             irq_q;

  assign up_cond   = avg > up_thr;
  assign dn_cond   = avg < dn_thr;
  assign pnc_cond  = avg >= pnc_thr;
  assign up_full   = up_cond && need_met(int'(up_cnt), int'(up_need));
  assign dn_full   = dn_cond && need_met(int'(dn_cnt), int'(dn_need));
  assign at_top    = level == LVL_TOP;
  assign at_bottom = level == '0;

  always_comb begin
    if (pnc_cond && !at_top)     cand = REQ_EMERG;
    else if (up_full && !at_top) cand = REQ_UP;
    else if (dn_full && !at_bottom) cand = REQ_DOWN;
    else                         cand = REQ_NONE;
  end

  assign gate_ok = en && !irq_mask && upd_ok && !irq_q;
  assign issue   = eval && gate_ok && (cand != REQ_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_cnt <= '0;
      dn_cnt <= '0;
    end else if (eval) begin
      if (issue) begin
        up_cnt <= '0;
        dn_cnt <= '0;
      end else begin
        up_cnt <= !up_cond ? '0 : ((up_cnt == '1) ? up_cnt : up_cnt + 1'b1);
        dn_cnt <= !dn_cond ? '0 : ((dn_cnt == '1) ? dn_cnt : dn_cnt + 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      req_q <= REQ_NONE;
    end else if (issue) begin
      irq_q <= 1'b1;
      req_q <= cand;
    end else if (ack) begin
      irq_q <= 1'b0;
      req_q <= REQ_NONE;
    end
  end

  assign req_code = req_q;
  assign irq      = irq_q;

  // R12: a pending request keeps its code until acknowledged
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !ack |=> irq_q && $stable(req_q));
  // R12: acknowledge clears code and interrupt
  p_ack_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && ack |=> !irq_q && (req_q == REQ_NONE));
  // R10: a new request only appears when the gating inputs allowed it
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(en && !irq_mask && upd_ok));
  // R9: no request past the level limits
  p_limits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> !(($past(level) == '0) && (req_q == REQ_DOWN)) &&
                     !(($past(level) == LVL_TOP) && (req_q inside {REQ_UP, REQ_EMERG})));
  // R11: a failed sample restarts the up count
  p_up_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eval && !up_cond |=> up_cnt == '0);
  // R11: raising a request restarts both counts
  p_issue_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (up_cnt == '0) && (dn_cnt == '0));
  // R12: a pending interrupt always carries a nonzero code
  p_code_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> req_q != REQ_NONE);

endmodule

// File: rtl/dvfs_load_tracker.sv
module dvfs_load_tracker
  import dvfs_lt_pkg::*;
#(
  parameter int LOAD_W = 6,
  parameter int NUM_GP = 16,
  parameter int WGT_W  = 3,
  parameter int FRAC_W = 8,
  parameter int K_W    = 3,
  parameter int DIV_W  = 4,
  parameter int CNT_W  = 8,
  parameter int LVL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    irq_mask,
  input  logic                    upd_ok,
  input  logic [LVL_W-1:0]        level,
  input  logic                    ack,
  input  logic [DIV_W-1:0]        tick_div,
  input  logic [LOAD_W-1:0]       load_in,
  input  logic [NUM_GP-1:0]       gp_act,
  input  logic [NUM_GP*WGT_W-1:0] gp_wgt,
  input  logic                    src_cur,
  input  logic [K_W-1:0]          ema_shift,
  input  logic [LOAD_W-1:0]       up_thr,
  input  logic [LOAD_W-1:0]       dn_thr,
  input  logic [LOAD_W-1:0]       pnc_thr,
  input  logic [CNT_W-1:0]        up_need,
  input  logic [CNT_W-1:0]        dn_need,
  output logic [1:0]              req_code,
  output logic                    irq
);
  logic              tick;
  logic [LOAD_W-1:0] avg;
  logic              avg_vld;

  dvfs_lt_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .div(tick_div), .tick(tick)
  );

  dvfs_lt_avg #(
    .LOAD_W(LOAD_W), .NUM_GP(NUM_GP), .WGT_W(WGT_W), .FRAC_W(FRAC_W), .K_W(K_W)
  ) u_avg (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_in(load_in),
    .gp_act(gp_act), .gp_wgt(gp_wgt), .src_cur(src_cur),
    .ema_shift(ema_shift), .avg(avg), .avg_vld(avg_vld)
  );

  dvfs_lt_decide #(.LOAD_W(LOAD_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .eval(avg_vld), .avg(avg),
    .up_thr(up_thr), .dn_thr(dn_thr), .pnc_thr(pnc_thr),
    .up_need(up_need), .dn_need(dn_need), .en(en), .irq_mask(irq_mask),
    .upd_ok(upd_ok), .level(level), .ack(ack),
    .req_code(req_code), .irq(irq)
  );

  // R1: idle after reset until a judgement raises something
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(avg_vld));

endmodule

// File: tb/tb_dvfs_load_tracker.sv
module tb_dvfs_load_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, en, irq_mask, upd_ok, ack, src_cur;
  logic [1:0]  level;
  logic [3:0]  tick_div;
  logic [5:0]  load_in, up_thr, dn_thr, pnc_thr;
  logic [15:0] gp_act;
  logic [47:0] gp_wgt;
  logic [2:0]  ema_shift;
  logic [7:0]  up_need, dn_need;
  logic [1:0]  req_code;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dvfs_load_tracker dut (
    .clk(clk), .rst_n(rst_n), .en(en), .irq_mask(irq_mask), .upd_ok(upd_ok),
    .level(level), .ack(ack), .tick_div(tick_div), .load_in(load_in),
    .gp_act(gp_act), .gp_wgt(gp_wgt), .src_cur(src_cur), .ema_shift(ema_shift),
    .up_thr(up_thr), .dn_thr(dn_thr), .pnc_thr(pnc_thr),
    .up_need(up_need), .dn_need(dn_need), .req_code(req_code), .irq(irq)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // quiet configuration: no request can fire until a test opens a path
  task automatic setup();
    rst_n = 1'b0; en = 1'b0; irq_mask = 1'b0; upd_ok = 1'b1; ack = 1'b0;
    level = 2'd1; tick_div = 4'd3; load_in = 6'd40; gp_act = '0;
    gp_wgt = '0;
    for (int i = 12; i < 16; i++) gp_wgt[3*i +: 3] = 3'd7;
    src_cur = 1'b1; ema_shift = 3'd0;
    up_thr = 6'd30; dn_thr = 6'd0; pnc_thr = 6'd63;
    up_need = 8'd3; dn_need = 8'd3;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go();
    rst_n = 1'b1; en = 1'b1;
  endtask

  task automatic t_reset();
    setup();
    check("R1 code", req_code, 0);
    check("R1 irq", irq, 0);
    rst_n = 1'b1;
    edges(20);
    check("R2 no request while disabled", irq, 0);
  endtask

  task automatic t_up_and_ack();
    setup(); go();
    edges(12); check("R6 up early", irq, 0);
    edges(1);  check("R6 up code", req_code, 1);
    check("R6 up irq", irq, 1);
    ack = 1'b1; edges(1); ack = 1'b0;          // edge 14 clears
    check("R12 ack clears code", req_code, 0);
    check("R12 ack clears irq", irq, 0);
    edges(10); check("R11 counts restart after issue", irq, 0);   // at 24
    edges(1);  check("R11 fresh request", req_code, 1);           // at 25
  endtask

  task automatic t_hold();
    setup(); go();
    edges(13); check("R12 raised", req_code, 1);
    load_in = 6'd5; dn_thr = 6'd18; dn_need = 8'd1;
    edges(20); check("R12 code held", req_code, 1);
    check("R12 irq held", irq, 1);
    ack = 1'b1; edges(1); ack = 1'b0;
    check("R12 cleared", irq, 0);
    edges(4); check("R7 decrease after ack", req_code, 2);
  endtask

  task automatic t_down();
    setup(); load_in = 6'd5; up_thr = 6'd62; dn_thr = 6'd18; dn_need = 8'd2;
    go();
    edges(8); check("R7 down early", irq, 0);
    edges(1); check("R7 down code", req_code, 2);
  endtask

  task automatic t_emerg();
    setup(); load_in = 6'd63; up_need = 8'd10; go();
    edges(4); check("R8 emergency early", irq, 0);
    edges(1); check("R8 emergency first sample", req_code, 3);
  endtask

  task automatic t_weights();
    setup(); load_in = 6'd10; up_thr = 6'd16; up_need = 8'd1;
    gp_act = 16'h0008; go();                   // weight 0 on input 3
    edges(12); check("R3 zero weight ignored", irq, 0);
    gp_act = 16'h1008;                         // add input 12, weight 7
    edges(5); check("R3 weighted sum", req_code, 1);
    setup(); load_in = 6'd60; gp_act = 16'hF000; up_need = 8'd10; go();
    edges(5); check("R3 saturation to 63", req_code, 3);
  endtask

  task automatic t_prev_src();
    setup(); src_cur = 1'b0; up_need = 8'd1; go();
    edges(5); check("R4 previous sample first tick", irq, 0);
    edges(4); check("R4 previous sample second tick", req_code, 1);
  endtask

  task automatic t_ema();
    setup(); ema_shift = 3'd1; up_thr = 6'd36; up_need = 8'd1; go();
    edges(16); check("R5 average still below", irq, 0);
    edges(1);  check("R5 average crosses", req_code, 1);
  endtask

  task automatic t_limits();
    setup(); level = 2'd3; load_in = 6'd63; up_need = 8'd1; go();
    edges(20); check("R9 no up or emergency at top", req_code, 0);
    setup(); level = 2'd0; load_in = 6'd0; up_thr = 6'd62;
    dn_thr = 6'd18; dn_need = 8'd1; go();
    edges(20); check("R9 no decrease at bottom", req_code, 0);
  endtask

  task automatic t_gating();
    setup(); irq_mask = 1'b1; up_need = 8'd1; go();
    edges(20); check("R10 masked", irq, 0);
    irq_mask = 1'b0;
    edges(1); check("R10 mask released", req_code, 1);
    setup(); upd_ok = 1'b0; up_need = 8'd1; go();
    edges(20); check("R10 update pending", irq, 0);
    upd_ok = 1'b1;
    edges(1); check("R10 update done", req_code, 1);
  endtask

  task automatic t_div();
    setup(); tick_div = 4'd1; up_need = 8'd2; go();
    edges(4); check("R2 divider early", irq, 0);
    edges(1); check("R2 divider of 1", req_code, 1);
  endtask

  task automatic t_restart();
    setup(); go();
    edges(8); load_in = 6'd20;                 // third sample misses
    edges(4); load_in = 6'd40;
    edges(8); check("R11 restart on miss", irq, 0);   // at 20
    edges(4); check("R11 not yet", irq, 0);           // at 24
    edges(1); check("R11 after three fresh", req_code, 1);
  endtask

  initial begin
    t_reset();
    t_up_and_ack();
    t_hold();
    t_down();
    t_emerg();
    t_weights();
    t_prev_src();
    t_ema();
    t_limits();
    t_gating();
    t_div();
    t_restart();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule